// File: doc/BRIEF.md
# Configuration-Item Read Engine with Skip and Persistent Cursor

This block holds a small read-only table of configuration items and copies bytes from one of them into system memory. Software first writes a selector to choose an item. That write also rewinds the item's read cursor. Software then programs a 64-bit destination address, a byte count, a skip count and a control word through a 20-byte register window. Setting the go bit starts the engine. It first drops `skip` bytes from the item, then writes the next `length` bytes to memory one byte at a time over a valid/ready port. The destination address goes up by one on every accepted byte.

The cursor stays where it is between transfers and returns to zero only on a selector write. Software can therefore walk through one item with several chunked or scattered transfers. For example, it can send a header to one buffer and the payload to another without reading the whole item into a staging area. A narrow legacy data port reads 1, 2 or 4 bytes at the cursor and advances it by the same width.

Top module: `cfg_item_dma`

## Requirements
- R1: After a synchronous active-low reset, every window register reads 0, the selector and cursor are 0, and `mem_valid` is low.
- R2: The window offsets are destination address bits 31:0 at 0, address bits 63:32 at 4, length at 8, skip count at 12 and control at 16. Every register reads back what was written. Any other offset reads 0 and a write to it is ignored.
- R3: A control write stores only bits 1:0 of the written word (mask 0x3). Bit 0 is the error flag and bit 1 is the go/busy flag.
- R4: Item `n` (valid for `n` < 4) is `6+3n` bytes long, and its byte at offset `k` is `(16n + 7k + 1) mod 256`. A selector write sets the cursor to 0. A legacy read with size code 0, 1 or 2 returns 1, 2 or 4 bytes from the cursor, little-endian in the low bytes with upper bytes zero, and advances the cursor by that width.
- R5: Transfers do not rewind the cursor. Transfers of I bytes and then J bytes deliver the same bytes as one transfer of I+J bytes.
- R6: Once started, the engine discards as many item bytes as the skip register holds before its first memory write.
- R7: A transfer issues exactly `length` byte writes at consecutive addresses from the programmed address. Each write holds address and data steady while `mem_ready` is low. Afterwards the address register reads start+length and the length register reads 0.
- R8: The go bit reads 1 for the whole transfer and clears by itself after the last byte. While it is set, window writes, selector writes and legacy reads have no effect.
- R9: Bytes at or beyond the item's end are delivered as 0. The cursor never wraps back toward the start.
- R10: Starting with a selector that names no item sets the control register to 0x1 (error set, go clear) on that same edge and produces no memory writes.
- R11: A transfer with length 0 still consumes the skip bytes and then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_we | input | 1 | Selector write strobe |
| sel_wdata | input | 16 | Item number to select |
| data_rd | input | 1 | Legacy data-port read strobe |
| data_sz | input | 2 | Legacy read size code: 0=1, 1=2, else 4 bytes |
| data_rdata | output | 32 | Legacy read data at the cursor |
| reg_we | input | 1 | Window write strobe |
| reg_addr | input | 5 | Window byte offset |
| reg_wdata | input | 32 | Window write data |
| reg_rdata | output | 32 | Window read data for `reg_addr` |
| mem_valid | output | 1 | Memory byte write request |
| mem_ready | input | 1 | Memory accepts the byte |
| mem_addr | output | 64 | Destination byte address |
| mem_data | output | 8 | Byte to write |

## Verification
The hardest cases to reach from the ports are the ones where the cursor has already run past an item's end, or was left mid-item by an earlier transfer, when a new skip and copy begins. The stimulus builds these deliberately. It chains transfers on one selection with different destinations, and sets a skip on the short item so the copy runs off its end. A zero-length transfer is followed by a legacy read to show where the skip left the cursor. The busy-window case is held open by keeping `mem_ready` low while the bench tries register, selector and legacy-read accesses. Afterwards, the bench reads the cursor back through the legacy port to show none of them took effect.

// File: rtl/cfgdma_pkg.sv
// Shared constants, engine state type and the item content function.
// Assumes a 32-bit register window with word-aligned offsets.
package cfgdma_pkg;

    localparam logic [4:0] OFF_ADDR_LO = 5'd0;
    localparam logic [4:0] OFF_ADDR_HI = 5'd4;
    localparam logic [4:0] OFF_LEN     = 5'd8;
    localparam logic [4:0] OFF_SKIP    = 5'd12;
    localparam logic [4:0] OFF_CTL     = 5'd16;

    localparam int         CTL_W       = 2;
    localparam logic [1:0] CTL_MASK    = 2'b11;
    localparam int         CTL_ERR     = 0;
    localparam int         CTL_GO      = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SKIP = 2'd1,
        ST_COPY = 2'd2
    } eng_state_e;

    // Content of item idx at byte offset off (range checks done by caller).
    function automatic logic [7:0] item_byte(input logic [31:0] idx,
                                             input logic [31:0] off);
        logic [31:0] v;
        v = (idx << 4) + (off * 32'd7) + 32'd1;
        return v[7:0];
    endfunction

endpackage

// File: rtl/cfg_item_rom.sv
// Read-only item table, computed rather than stored.
// Gives LANES consecutive bytes starting at the cursor for the selected item.
// Bytes at or past the item's end, and all bytes of a missing item, are zero.
module cfg_item_rom
    import cfgdma_pkg::*;
#(
    parameter int SEL_W     = 16,
    parameter int CUR_W     = 16,
    parameter int NUM_ITEMS = 4,
    parameter int SIZE_BASE = 6,
    parameter int SIZE_STEP = 3,
    parameter int LANES     = 4
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [CUR_W-1:0]      cursor,
    output logic                  item_ok,
    output logic [LANES-1:0][7:0] lane_byte
);
    localparam int OFF_W = CUR_W + 2;

    logic [31:0] sel_ext;
    logic [31:0] item_len;

    // Selected item number, its validity and its length.
    assign sel_ext  = 32'(sel);
    assign item_ok  = sel_ext < 32'(NUM_ITEMS);
    assign item_len = 32'(SIZE_BASE) + 32'(SIZE_STEP) * sel_ext;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [OFF_W-1:0] off;
            logic [31:0]      off_ext;
            // Byte offset for this lane, widened so it cannot overflow.
            assign off       = OFF_W'(cursor) + OFF_W'(k);
            assign off_ext   = 32'(off);
            assign lane_byte[k] = (item_ok && (off_ext < item_len))
                                  ? item_byte(sel_ext, off_ext) : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/cfg_dma_regs.sv
// Register window: destination address, length, skip count and control.
// Assumes single-cycle 32-bit writes. Writes are ignored while the go bit is set.
// During a transfer, the address counts up and the length counts down once per accepted byte.
module cfg_dma_regs
    import cfgdma_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [4:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               item_ok,
    input  logic               acc,
    input  logic               fin,
    output logic [2*REG_W-1:0] dst_addr,
    output logic [REG_W-1:0]   len_q,
    output logic [REG_W-1:0]   skip_q,
    output logic               busy,
    output logic               start_go
);
    logic [2*REG_W-1:0] addr_q;
    logic [CTL_W-1:0]   ctl_q;
    logic               wr_ok;
    logic               go_req;

    // Write acceptance and start decode.
    assign busy     = ctl_q[CTL_GO];
    assign wr_ok    = reg_we && !busy;
    assign go_req   = wr_ok && (reg_addr == OFF_CTL) && reg_wdata[CTL_GO];
    assign start_go = go_req && item_ok;
    assign dst_addr = addr_q;

    // Register storage, software writes and transfer-time updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            skip_q <= '0;
            ctl_q  <= '0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFF_ADDR_LO: addr_q[REG_W-1:0]       <= reg_wdata;
                OFF_ADDR_HI: addr_q[2*REG_W-1:REG_W] <= reg_wdata;
                OFF_LEN:     len_q                   <= reg_wdata;
                OFF_SKIP:    skip_q                  <= reg_wdata;
                OFF_CTL: begin
                    if (go_req && !item_ok)
                        ctl_q <= 2'b01;
                    else
                        ctl_q <= reg_wdata[CTL_W-1:0] & CTL_MASK;
                end
                default: ;
            endcase
        end else if (busy) begin
            if (acc) begin
                addr_q <= addr_q + 1'b1;
                len_q  <= len_q - 1'b1;
            end
            if (fin)
                ctl_q[CTL_GO] <= 1'b0;
        end
    end

    // Combinational readback of the window.
    always_comb begin
        case (reg_addr)
            OFF_ADDR_LO: reg_rdata = addr_q[REG_W-1:0];
            OFF_ADDR_HI: reg_rdata = addr_q[2*REG_W-1:REG_W];
            OFF_LEN:     reg_rdata = len_q;
            OFF_SKIP:    reg_rdata = skip_q;
            OFF_CTL:     reg_rdata = REG_W'(ctl_q);
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_dma_seq.sv
// Selector, read cursor and the skip-then-copy sequencer.
// The cursor returns to zero only on a selector write and saturates at its maximum instead of wrapping.
// Assumes start_go is only raised while idle.
module cfg_dma_seq
    import cfgdma_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int CUR_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             data_rd,
    input  logic [3:0]       rd_step,
    input  logic [REG_W-1:0] len_q,
    input  logic [REG_W-1:0] skip_q,
    input  logic             mem_ready,
    output logic [SEL_W-1:0] sel_q,
    output logic [CUR_W-1:0] cursor_q,
    output logic             mem_valid,
    output logic             acc,
    output logic             fin
);
    eng_state_e       st_q;
    logic [REG_W-1:0] skip_left_q;

    // Saturating cursor advance.
    function automatic logic [CUR_W-1:0] cur_add(input logic [CUR_W-1:0] c,
                                                 input logic [3:0] inc);
        logic [CUR_W:0] s;
        s = {1'b0, c} + (CUR_W+1)'(inc);
        return s[CUR_W] ? {CUR_W{1'b1}} : s[CUR_W-1:0];
    endfunction

    // Copy-phase handshake and completion detection.
    always_comb begin
        mem_valid = (st_q == ST_COPY) && (len_q != '0);
        acc       = mem_valid && mem_ready;
        fin       = (st_q == ST_COPY) && (len_q == '0);
    end

    // Sequencer state, skip counter, selector and cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            skip_left_q <= '0;
            sel_q       <= '0;
            cursor_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_go) begin
                        st_q        <= ST_SKIP;
                        skip_left_q <= skip_q;
                    end else if (sel_we) begin
                        sel_q    <= sel_wdata;
                        cursor_q <= '0;
                    end else if (data_rd) begin
                        cursor_q <= cur_add(cursor_q, rd_step);
                    end
                end
                ST_SKIP: begin
                    if (skip_left_q == '0) begin
                        st_q <= ST_COPY;
                    end else begin
                        skip_left_q <= skip_left_q - 1'b1;
                        cursor_q    <= cur_add(cursor_q, 4'd1);
                    end
                end
                ST_COPY: begin
                    if (fin)
                        st_q <= ST_IDLE;
                    else if (acc)
                        cursor_q <= cur_add(cursor_q, 4'd1);
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_item_dma.sv
// Top level: configuration-item read engine with a register window,
// a legacy narrow data port and a byte-wide valid/ready memory write port.
// Assumes the memory side holds mem_ready stable across the clock edge.
module cfg_item_dma
    import cfgdma_pkg::*;
#(
    parameter int SEL_W     = 16,
    parameter int CUR_W     = 16,
    parameter int REG_W     = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_ITEMS = 4,
    parameter int SIZE_BASE = 6,
    parameter int SIZE_STEP = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_we,
    input  logic [SEL_W-1:0]    sel_wdata,
    input  logic                data_rd,
    input  logic [1:0]          data_sz,
    output logic [DATA_W-1:0]   data_rdata,
    input  logic                reg_we,
    input  logic [4:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [2*REG_W-1:0]  mem_addr,
    output logic [7:0]          mem_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int ADDR_W = 2 * REG_W;

    logic [SEL_W-1:0]      sel_q;
    logic [CUR_W-1:0]      cursor_q;
    logic                  item_ok;
    logic [LANES-1:0][7:0] lane_byte;
    logic [REG_W-1:0]      len_q;
    logic [REG_W-1:0]      skip_q;
    logic [ADDR_W-1:0]     dst_addr;
    logic                  busy;
    logic                  start_go;
    logic                  acc;
    logic                  fin;
    logic [3:0]            rd_width;
    logic                  rd_acc;
    logic                  sel_acc;

    // Legacy access width from the size code, capped at the port width.
    always_comb begin
        case (data_sz)
            2'd0:    rd_width = 4'd1;
            2'd1:    rd_width = (LANES >= 2) ? 4'd2 : 4'(LANES);
            default: rd_width = (LANES >= 4) ? 4'd4 : 4'(LANES);
        endcase
    end

    // Selector and legacy reads act only while idle.
    assign sel_acc = sel_we && !busy;
    assign rd_acc  = data_rd && !busy;

    cfg_item_rom #(
        .SEL_W(SEL_W), .CUR_W(CUR_W), .NUM_ITEMS(NUM_ITEMS),
        .SIZE_BASE(SIZE_BASE), .SIZE_STEP(SIZE_STEP), .LANES(LANES)
    ) u_rom (
        .sel(sel_q), .cursor(cursor_q), .item_ok(item_ok), .lane_byte(lane_byte)
    );

    cfg_dma_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .item_ok(item_ok),
        .acc(acc), .fin(fin), .dst_addr(dst_addr), .len_q(len_q),
        .skip_q(skip_q), .busy(busy), .start_go(start_go)
    );

    cfg_dma_seq #(.SEL_W(SEL_W), .CUR_W(CUR_W), .REG_W(REG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_go(start_go), .sel_we(sel_acc),
        .sel_wdata(sel_wdata), .data_rd(rd_acc), .rd_step(rd_width),
        .len_q(len_q), .skip_q(skip_q), .mem_ready(mem_ready),
        .sel_q(sel_q), .cursor_q(cursor_q), .mem_valid(mem_valid),
        .acc(acc), .fin(fin)
    );

    assign mem_addr = dst_addr;
    assign mem_data = lane_byte[0];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_rd
            // Bytes beyond the access width read as zero.
            assign data_rdata[8*k +: 8] = (4'(k) < rd_width) ? lane_byte[k] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/cfg_item_dma_chk.sv
// Protocol and cursor checks for cfg_item_dma, attached with bind.
module cfg_item_dma_chk #(
    parameter int ADDR_W = 64,
    parameter int CUR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_data,
    input logic              busy,
    input logic              item_ok,
    input logic              sel_we,
    input logic [CUR_W-1:0]  cursor
);
    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R7
    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> mem_addr == $past(mem_addr) + 1'b1); // R7
    AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy); // R8
    AST_NO_WRITE_BAD_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        !item_ok |-> !mem_valid); // R10
    AST_SELECT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we && !busy |=> cursor == '0); // R4
    AST_CURSOR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cursor >= $past(cursor)); // R9
endmodule

bind cfg_item_dma cfg_item_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .item_ok(item_ok),
    .sel_we(sel_we), .cursor(cursor_q)
);

// File: tb/tb_cfg_item_dma.sv
module tb_cfg_item_dma;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic        data_rd = 1'b0;
    logic [1:0]  data_sz = '0;
    logic [31:0] data_rdata;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_addr;
    logic [7:0]  mem_data;

    int n_chk = 0;
    int n_fail = 0;
    bit hold = 1'b0;
    int tb_sel = 0;
    int tb_cur = 0;
    logic [63:0] cap_a[$];
    logic [7:0]  cap_d[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_item_dma dut (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .data_rd(data_rd), .data_sz(data_sz), .data_rdata(data_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    function automatic logic [7:0] exp_byte(input int item, input int off);
        int v;
        if (item < 0 || item >= 4 || off >= 6 + 3*item) return 8'h00;
        v = 16*item + 7*off + 1;
        return v[7:0];
    endfunction

    function automatic logic [31:0] exp_word(input int item, input int off, input int w);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < w; k++) r[8*k +: 8] = exp_byte(item, off + k);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference of the engine, stepped on every clock.
    int          m_st, m_sel, m_cur;
    longint unsigned m_len, m_skip, m_skl;
    logic [63:0] m_addr;
    logic [1:0]  m_ctl;

    always @(posedge clk) begin : model
        bit busy, ok, fin, acc, go;
        int w;
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_cur = 0; m_len = 0; m_skip = 0; m_skl = 0;
            m_addr = '0; m_ctl = '0;
        end else begin
            busy = m_ctl[1];
            ok   = (m_sel < 4);
            fin  = (m_st == 2) && (m_len == 0);
            acc  = (m_st == 2) && (m_len != 0) && mem_ready;
            go   = reg_we && !busy && reg_addr == 5'd16 && reg_wdata[1] && ok;
            w    = (data_sz == 2'd0) ? 1 : (data_sz == 2'd1) ? 2 : 4;
            if (m_st == 0) begin
                if (go) begin m_st = 1; m_skl = m_skip; end
                else if (sel_we) begin m_sel = int'(sel_wdata); m_cur = 0; end
                else if (data_rd) m_cur = (m_cur + w > 65535) ? 65535 : m_cur + w;
            end else if (m_st == 1) begin
                if (m_skl == 0) m_st = 2;
                else begin m_skl--; m_cur = (m_cur + 1 > 65535) ? 65535 : m_cur + 1; end
            end else begin
                if (fin) m_st = 0;
                else if (acc) m_cur = (m_cur + 1 > 65535) ? 65535 : m_cur + 1;
            end
            if (reg_we && !busy) begin
                case (reg_addr)
                    5'd0:  m_addr[31:0]  = reg_wdata;
                    5'd4:  m_addr[63:32] = reg_wdata;
                    5'd8:  m_len  = reg_wdata;
                    5'd12: m_skip = reg_wdata;
                    5'd16: m_ctl  = (reg_wdata[1] && !ok) ? 2'b01 : reg_wdata[1:0];
                    default: ;
                endcase
            end else if (busy) begin
                if (acc) begin m_addr = m_addr + 1; m_len--; end
                if (fin) m_ctl[1] = 1'b0;
            end
        end
    end

    // Per-cycle comparison of the memory port against the model (R7).
    always @(negedge clk) begin
        bit ev;
        if (rst_n) begin
            ev = (m_st == 2) && (m_len != 0);
            check(mem_valid == ev, "R7 valid", mem_valid, ev);
            if (ev && mem_valid)
                check(mem_addr == m_addr && mem_data == exp_byte(m_sel, m_cur),
                      "R7 addr/data", {mem_addr[55:0], mem_data}, {m_addr[55:0], exp_byte(m_sel, m_cur)});
        end
    end

    always @(negedge clk) mem_ready <= hold ? 1'b0 : ($urandom % 4 != 0);

    always @(posedge clk)
        if (rst_n && mem_valid && mem_ready) begin
            cap_a.push_back(mem_addr);
            cap_d.push_back(mem_data);
        end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic sel(input int v);
        @(negedge clk); sel_we = 1'b1; sel_wdata = 16'(v);
        @(negedge clk); sel_we = 1'b0;
        tb_sel = v; tb_cur = 0;
    endtask

    task automatic legacy(input logic [1:0] sz, input string req);
        logic [31:0] d, e;
        int w;
        w = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        e = exp_word(tb_sel, tb_cur, w);
        @(negedge clk); data_rd = 1'b1; data_sz = sz; #1; d = data_rdata;
        @(negedge clk); data_rd = 1'b0;
        check(d == e, req, d, e);
        tb_cur += w;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        rd(5'd16, v);
        while (v[1] && n < 3000) begin @(negedge clk); rd(5'd16, v); n++; end
        check(!v[1], req, v, 0);
    endtask

    task automatic xfer(input logic [63:0] base, input int len, input int skip,
                        input string req, input bit probe);
        int st, bad;
        logic [31:0] v;
        st = cap_d.size();
        wr(5'd0, base[31:0]); wr(5'd4, base[63:32]);
        wr(5'd8, 32'(len));   wr(5'd12, 32'(skip));
        if (probe) hold = 1'b1;
        wr(5'd16, 32'h2);
        if (probe) begin
            rd(5'd16, v); check(v == 32'h2, "R8 go bit set while running", v, 2);
            wr(5'd8, 32'd99);
            rd(5'd8, v); check(v == 32'(len), "R8 length write ignored when busy", v, len);
            @(negedge clk); sel_we = 1'b1; sel_wdata = 16'd0;
            @(negedge clk); sel_we = 1'b0; data_rd = 1'b1; data_sz = 2'd2;
            @(negedge clk); data_rd = 1'b0;
            hold = 1'b0;
        end
        wait_idle({req, " completion"});
        check(cap_d.size() == st + len, {req, " byte count"}, cap_d.size() - st, len);
        bad = 0;
        for (int k = 0; k < len && st + k < cap_d.size(); k++)
            if (cap_d[st+k] != exp_byte(tb_sel, tb_cur + skip + k) || cap_a[st+k] != base + 64'(k))
                bad++;
        check(bad == 0, {req, " stream contents"}, bad, 0);
        tb_cur += skip + len;
    endtask

    task automatic finish_report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_report();
    end

    initial begin : stim
        logic [31:0] v;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(5'd0, v);  check(v == 0, "R1 addr lo", v, 0);
        rd(5'd4, v);  check(v == 0, "R1 addr hi", v, 0);
        rd(5'd8, v);  check(v == 0, "R1 length", v, 0);
        rd(5'd12, v); check(v == 0, "R1 skip", v, 0);
        rd(5'd16, v); check(v == 0, "R1 control", v, 0);
        check(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
        legacy(2'd1, "R1 selector and cursor zero");

        // R2: window offsets and readback
        wr(5'd0, 32'hA5A5_0001); wr(5'd4, 32'h0000_0001);
        wr(5'd8, 32'd7);         wr(5'd12, 32'd3);
        rd(5'd0, v);  check(v == 32'hA5A5_0001, "R2 addr lo", v, 32'hA5A5_0001);
        rd(5'd4, v);  check(v == 32'h1, "R2 addr hi", v, 1);
        rd(5'd8, v);  check(v == 32'd7, "R2 length", v, 7);
        rd(5'd12, v); check(v == 32'd3, "R2 skip", v, 3);
        wr(5'd20, 32'hFFFF_FFFF);
        rd(5'd20, v); check(v == 0, "R2 unmapped offset", v, 0);
        rd(5'd8, v);  check(v == 32'd7, "R2 unmapped write ignored", v, 7);

        // R3: control mask
        wr(5'd16, 32'hFFFF_FFFD);
        rd(5'd16, v); check(v == 32'h1, "R3 masked control", v, 1);
        wr(5'd16, 32'h0);
        rd(5'd16, v); check(v == 32'h0, "R3 control cleared", v, 0);

        // R4: selector rewinds, legacy widths
        sel(1);
        legacy(2'd0, "R4 legacy byte");
        legacy(2'd1, "R4 legacy half");
        legacy(2'd2, "R4 legacy word");
        sel(1);
        legacy(2'd0, "R4 cursor rewound by selector");

        // R5 / R7: chunked, scattered transfers keep the cursor
        sel(2);
        xfer(64'h1_0000_0100, 5, 0, "R5 first chunk", 1'b0);
        xfer(64'h0000_9000, 4, 0, "R5 second chunk", 1'b0);
        rd(5'd0, v); check(v == 32'h9004, "R7 address after transfer", v, 32'h9004);
        rd(5'd8, v); check(v == 0, "R7 length counted down", v, 0);

        // R6: skip before copy
        sel(3);
        xfer(64'h2000, 4, 3, "R6 skip then copy", 1'b0);

        // R9: past-end bytes are zero
        sel(0);
        xfer(64'h3000, 5, 4, "R9 copy past end", 1'b0);
        legacy(2'd2, "R9 no wrap after end");

        // R10: invalid item
        sel(9);
        c0 = cap_d.size();
        wr(5'd8, 32'd4); wr(5'd12, 32'd0);
        wr(5'd16, 32'h2);
        rd(5'd16, v); check(v == 32'h1, "R10 error set, go clear", v, 1);
        repeat (20) @(negedge clk);
        check(cap_d.size() == c0, "R10 no memory writes", cap_d.size() - c0, 0);

        // R11: zero length still skips
        sel(1);
        xfer(64'h4000, 0, 2, "R11 zero length", 1'b0);
        legacy(2'd0, "R11 skip consumed");

        // R8: accesses during a transfer have no effect
        sel(2);
        xfer(64'h5000, 6, 1, "R8 held transfer", 1'b1);
        legacy(2'd0, "R8 selector and legacy read ignored while busy");

        repeat (5) @(negedge clk);
        finish_report();
    end

endmodule